// File: doc/BRIEF.md
# Split-Phase Optical-Black Level Corrector

This block sits behind the analog-to-digital converter of a linear CCD line. Every digitized sample arrives with its element index inside the line, counted from 0 at the first element clocked out. A run of shielded reference elements near the start of each line gives the dark level. The odd and even phases of the CCD register can settle at different offsets, so the block averages the even-indexed references and the odd-indexed references separately. It then removes the matching dark level from every image pixel, choosing by the parity of the pixel's index.

The reference window covers indices 24 to 53: fifteen even elements (24, 26 … 52) and fifteen odd elements (25, 27 … 53). Image pixels occupy indices 56 to 3055. The trailing dummy elements 3056 to 3065 and all leading elements outside the window are discarded. Each phase is summed without loss. Dividing by fifteen is done by multiplying with a fixed-point reciprocal, which gives the exact floor of the quotient. Both dark levels are latched when the last reference element is accepted, so the image pixels of the same line already use them. Corrected pixels leave the block two clocks after they enter, and a result below zero is clamped to 0.

Top module: `ob_black_corrector`

## Requirements
- R1: While reset is held and right after it, `pix_valid` is 0 and `pix_data`, `blk_even` and `blk_odd` are all 0.
- R2: When a valid sample with index 53 is accepted, `blk_even` takes the floor of the sum of the valid samples at even indices 24..52 since the last line start, divided by 15. The new value is visible after that clock edge.
- R3: At the same edge, `blk_odd` takes the floor of the sum of the odd indices 25..53 divided by 15. The index-53 sample accepted in that cycle is part of the sum.
- R4: Samples whose index lies outside 24..53 have no effect on either dark level.
- R5: `blk_even` and `blk_odd` change only at the edge that accepts index 53. A line start does not change them: they hold through the next line's leading elements.
- R6: A `line_start` pulse clears both reference sums, so each line's dark levels depend only on that line's references. A window sample that arrives in the same cycle as the pulse counts as the first term.
- R7: For a valid sample with index 56..3055, the output is the sample minus `blk_even` if bit 0 of the index is 0, and minus `blk_odd` if bit 0 is 1.
- R8: When that difference would be negative, `pix_data` is 0.
- R9: A corrected pixel appears with `pix_valid` high exactly two clock edges after the edge that accepts its sample. Idle cycles with `smp_valid` low produce no output.
- R10: Samples with index 0..55 or 3056..3065 never raise `pix_valid`.
- R11: The sums stay exact at full scale: fifteen samples of 4095 give a dark level of 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_start | input | 1 | One-cycle pulse marking the start of a line |
| smp_valid | input | 1 | `smp_data`/`smp_idx` carry a sample this cycle |
| smp_idx | input | 12 | Element index of the sample within the line |
| smp_data | input | 12 | Digitized sample value |
| pix_valid | output | 1 | `pix_data` holds a corrected image pixel |
| pix_data | output | 12 | Dark-corrected pixel value |
| blk_even | output | 12 | Latched dark level of the even phase |
| blk_odd | output | 12 | Latched dark level of the odd phase |

## Verification
Two functions meet in one cycle when the index-53 sample arrives. That sample is added to the odd sum, and the same edge latches both quotients, so the latched odd level must already include it. The bench computes both averages from the full fifteen-term sums in every line and compares them with the latched levels. A missing final term shows up as a wrong odd level, and as wrong corrected odd pixels afterwards. A second collision happens at the line boundary, where the line-start pulse must clear the sums while the previous dark levels stay on the outputs. The bench checks that the old levels are still present in the middle of the next line's leading elements.

// File: rtl/ob_pkg.sv
// Package: shared types and constant helpers for the dark-level corrector.
// Assumes divisors and shifts small enough for 64-bit arithmetic.
package ob_pkg;

    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } phase_e;

    // Smallest integer not below 2**shift / div.
    function automatic longint unsigned ceil_recip(input int unsigned div,
                                                   input int unsigned shift);
        longint unsigned num;
        num = longint'(1) << shift;
        return (num + longint'(div) - 1) / longint'(div);
    endfunction

endpackage

// File: rtl/ob_index_classify.sv
// Module: decodes the element index into window flags.
// Assumes index values come straight from the line counter of the readout.
module ob_index_classify #(
    parameter int IDX_W     = 12,
    parameter int BLK_FIRST = 24,
    parameter int BLK_LAST  = 53,
    parameter int EFF_FIRST = 56,
    parameter int EFF_LAST  = 3055
) (
    input  logic [IDX_W-1:0] idx,
    output logic             in_black,
    output logic             black_end,
    output logic             in_eff,
    output ob_pkg::phase_e   phase
);

    // Range compares on the raw index.
    always_comb begin
        in_black  = (idx >= IDX_W'(BLK_FIRST)) && (idx <= IDX_W'(BLK_LAST));
        black_end = (idx == IDX_W'(BLK_LAST));
        in_eff    = (idx >= IDX_W'(EFF_FIRST)) && (idx <= IDX_W'(EFF_LAST));
        phase     = idx[0] ? ob_pkg::PH_ODD : ob_pkg::PH_EVEN;
    end

endmodule

// File: rtl/ob_phase_accum.sv
// Module: sums one phase's reference samples and latches their floor average.
// Assumes at most N_TERMS samples per line, so SUM_W bits never overflow.
module ob_phase_accum #(
    parameter int DATA_W  = 12,
    parameter int N_TERMS = 15,
    parameter int SUM_W   = DATA_W + $clog2(N_TERMS),
    parameter int SHIFT   = SUM_W + $clog2(N_TERMS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              add_en,
    input  logic [DATA_W-1:0] sample,
    input  logic              latch_en,
    output logic [DATA_W-1:0] level
);

    localparam longint unsigned RECIP = ob_pkg::ceil_recip(N_TERMS, SHIFT);
    localparam int RW     = SHIFT + 1;
    localparam int PROD_W = SUM_W + RW;

    logic [SUM_W-1:0]  acc_q;
    logic [SUM_W-1:0]  sum_next;
    logic [PROD_W-1:0] prod;

    // Next sum: clear on line start, then add this cycle's term.
    always_comb begin
        sum_next = (clear ? '0 : acc_q) + (add_en ? SUM_W'(sample) : '0);
        prod     = PROD_W'(sum_next) * PROD_W'(RECIP[RW-1:0]);
    end

    // Running sum register and latched quotient.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            level <= '0;
        end else begin
            acc_q <= sum_next;
            if (latch_en) begin
                level <= DATA_W'(prod >> SHIFT);
            end
        end
    end

endmodule

// File: rtl/ob_sub_pipe.sv
// Module: two-stage pipe that subtracts the phase's dark level with a floor at 0.
// Assumes dark levels are stable while image pixels flow.
module ob_sub_pipe #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_fire,
    input  logic [DATA_W-1:0] in_data,
    input  ob_pkg::phase_e    in_phase,
    input  logic [DATA_W-1:0] lvl_even,
    input  logic [DATA_W-1:0] lvl_odd,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    logic              s1_valid;
    logic [DATA_W-1:0] s1_data;
    ob_pkg::phase_e    s1_phase;
    logic [DATA_W-1:0] ref_sel;
    logic [DATA_W-1:0] diff;

    // Stage 1 capture of an image sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_data  <= '0;
            s1_phase <= ob_pkg::PH_EVEN;
        end else begin
            s1_valid <= in_fire;
            if (in_fire) begin
                s1_data  <= in_data;
                s1_phase <= in_phase;
            end
        end
    end

    // Pick the reference by phase and subtract with a floor at zero.
    always_comb begin
        ref_sel = (s1_phase == ob_pkg::PH_ODD) ? lvl_odd : lvl_even;
        diff    = (s1_data > ref_sel) ? (s1_data - ref_sel) : '0;
    end

    // Stage 2 output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_data <= diff;
            end
        end
    end

endmodule

// File: rtl/ob_black_corrector.sv
// Module: top of the split-phase dark-level corrector.
// Assumes one sample per valid cycle, indices ascending within a line,
// and a line_start pulse before each line's reference window.
module ob_black_corrector #(
    parameter int DATA_W    = 12,
    parameter int IDX_W     = 12,
    parameter int BLK_FIRST = 24,
    parameter int BLK_LAST  = 53,
    parameter int EFF_FIRST = 56,
    parameter int EFF_COUNT = 3000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic              smp_valid,
    input  logic [IDX_W-1:0]  smp_idx,
    input  logic [DATA_W-1:0] smp_data,
    output logic              pix_valid,
    output logic [DATA_W-1:0] pix_data,
    output logic [DATA_W-1:0] blk_even,
    output logic [DATA_W-1:0] blk_odd
);

    localparam int EFF_LAST = EFF_FIRST + EFF_COUNT - 1;
    localparam int N_TERMS  = (BLK_LAST - BLK_FIRST + 1) / 2;
    localparam int N_PHASE  = 2;

    logic           in_black;
    logic           black_end;
    logic           in_eff;
    ob_pkg::phase_e phase;
    logic [DATA_W-1:0] lvl [N_PHASE];

    ob_index_classify #(
        .IDX_W(IDX_W), .BLK_FIRST(BLK_FIRST), .BLK_LAST(BLK_LAST),
        .EFF_FIRST(EFF_FIRST), .EFF_LAST(EFF_LAST)
    ) classify_i (
        .idx(smp_idx), .in_black(in_black), .black_end(black_end),
        .in_eff(in_eff), .phase(phase)
    );

    for (genvar p = 0; p < N_PHASE; p++) begin : g_phase
        logic add_en;
        // Route a window sample of this phase into its accumulator.
        always_comb add_en = smp_valid && in_black && (int'(phase) == p);

        ob_phase_accum #(
            .DATA_W(DATA_W), .N_TERMS(N_TERMS)
        ) accum_i (
            .clk(clk), .rst_n(rst_n), .clear(line_start),
            .add_en(add_en), .sample(smp_data),
            .latch_en(smp_valid && black_end), .level(lvl[p])
        );
    end

    // Expose the latched references.
    always_comb begin
        blk_even = lvl[0];
        blk_odd  = lvl[1];
    end

    ob_sub_pipe #(.DATA_W(DATA_W)) sub_i (
        .clk(clk), .rst_n(rst_n),
        .in_fire(smp_valid && in_eff), .in_data(smp_data), .in_phase(phase),
        .lvl_even(lvl[0]), .lvl_odd(lvl[1]),
        .out_valid(pix_valid), .out_data(pix_data)
    );

endmodule

// File: rtl/ob_black_corrector_chk.sv
// Checker: timing and value properties of the corrector's ports.
module ob_black_corrector_chk #(
    parameter int DATA_W    = 12,
    parameter int IDX_W     = 12,
    parameter int BLK_LAST  = 53,
    parameter int EFF_FIRST = 56,
    parameter int EFF_COUNT = 3000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_valid,
    input logic [IDX_W-1:0]  smp_idx,
    input logic [DATA_W-1:0] smp_data,
    input logic              pix_valid,
    input logic [DATA_W-1:0] pix_data,
    input logic [DATA_W-1:0] blk_even,
    input logic [DATA_W-1:0] blk_odd
);

    localparam int EFF_LAST = EFF_FIRST + EFF_COUNT - 1;

    logic [1:0] since_rst;
    logic       eff_in;

    // Count up to two cycles since reset so past values are meaningful.
    always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    always_comb eff_in = smp_valid && (smp_idx >= IDX_W'(EFF_FIRST))
                         && (smp_idx <= IDX_W'(EFF_LAST));

    assert_valid_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (since_rst >= 2'd2) && $past(eff_in, 2));

    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) && $past(eff_in, 2) |-> pix_valid);

    assert_not_above_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) && pix_valid |-> pix_data <= $past(smp_data, 2));

    assert_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) && pix_valid &&
        ($past(smp_data, 2) <= ($past(smp_idx[0], 2) ? blk_odd : blk_even))
        |-> pix_data == '0);

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1) && !$past(smp_valid && smp_idx == IDX_W'(BLK_LAST))
        |-> $stable(blk_even) && $stable(blk_odd));

endmodule

bind ob_black_corrector ob_black_corrector_chk #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .BLK_LAST(BLK_LAST),
    .EFF_FIRST(EFF_FIRST), .EFF_COUNT(EFF_COUNT)
) chk_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_idx(smp_idx),
    .smp_data(smp_data), .pix_valid(pix_valid), .pix_data(pix_data),
    .blk_even(blk_even), .blk_odd(blk_odd)
);

// File: tb/ob_black_corrector_tb_top.sv
// Bench: drives whole lines of several patterns and checks each output pixel
// and the latched dark levels against arithmetic computed here.
module ob_black_corrector_tb_top;

    localparam int LINE_LEN = 3066;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_idx = '0;
    logic [11:0] smp_data = '0;
    logic        pix_valid;
    logic [11:0] pix_data;
    logic [11:0] blk_even;
    logic [11:0] blk_odd;

    int n_checks = 0;
    int n_errors = 0;
    int exp_blk [2] = '{0, 0};
    bit mon_on = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ob_black_corrector dut_i (
        .clk(clk), .rst_n(rst_n), .line_start(line_start),
        .smp_valid(smp_valid), .smp_idx(smp_idx), .smp_data(smp_data),
        .pix_valid(pix_valid), .pix_data(pix_data),
        .blk_even(blk_even), .blk_odd(blk_odd)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int gen(input int line, input int idx);
        bit win;
        win = (idx >= 24) && (idx <= 53);
        case (line)
            0: return win ? ((idx % 2 == 0) ? 90 + idx % 5 : 200 + idx % 7)
                          : 1000 + (idx * 7) % 2000;
            1: return win ? 2000 + (idx * 13) % 90 : (idx * 37) % 4096;
            2: return win ? 4095 : (idx * 5) % 4096;
            3: return ((idx * 1103 + 977) ^ (idx >> 3)) % 4096;
            default: return win ? 0 : ((idx < 24 || idx > 3055 || idx == 54 || idx == 55)
                                       ? 4095 : (idx * 11) % 4096);
        endcase
    endfunction

    task automatic drive(input bit ls, input bit v, input int idx, input int d);
        @(negedge clk);
        line_start = ls;
        smp_valid  = v;
        smp_idx    = 12'(idx);
        smp_data   = 12'(d);
    endtask

    // Drives one line; gaps inserts an idle cycle with junk after each sample.
    task automatic run_line(input int line, input bit gaps);
        int se, so, old_e, old_o;
        se = 0; so = 0;
        for (int i = 24; i <= 53; i++) begin
            if (i % 2 == 0) se += gen(line, i); else so += gen(line, i);
        end
        old_e = exp_blk[0];
        old_o = exp_blk[1];
        for (int i = 0; i < LINE_LEN; i++) begin
            drive(i == 0, 1'b1, i, gen(line, i));
            if (i == 53) begin
                exp_blk[0] = se / 15;
                exp_blk[1] = so / 15;
            end
            if (i == 30) begin
                // R5: previous line's levels still held after line start
                check(blk_even == 12'(old_e), "R5 even hold", blk_even, old_e);
                check(blk_odd == 12'(old_o), "R5 odd hold", blk_odd, old_o);
            end
            if (i == 54) begin
                // R2/R3/R4/R6/R11: fresh per-line floor averages
                check(blk_even == 12'(exp_blk[0]),
                      (line == 2) ? "R11 even full scale" : "R2 R4 R6 even level",
                      blk_even, exp_blk[0]);
                check(blk_odd == 12'(exp_blk[1]),
                      (line == 2) ? "R11 odd full scale" : "R3 R4 R6 odd level",
                      blk_odd, exp_blk[1]);
            end
            if (gaps) drive(1'b0, 1'b0, (i * 97) % 4096, (i * 31) % 4096);
        end
    endtask

    // Output monitor: compares with the input accepted one edge earlier.
    initial begin
        bit pv;
        int pd;
        pv = 1'b0; pd = 0;
        forever begin
            @(posedge clk);
            #2;
            if (mon_on) begin
                // R7/R8/R9/R10: valid timing and corrected value
                check(pix_valid == pv, pv ? "R9 valid expected" : "R10 no valid",
                      pix_valid, pv);
                if (pv && pix_valid)
                    check(pix_data == 12'(pd), (pd == 0) ? "R8 floor" : "R7 value",
                          pix_data, pd);
            end
            pv = smp_valid && smp_idx >= 56 && smp_idx <= 3055;
            if (pv) begin
                int r;
                r = exp_blk[smp_idx[0]];
                pd = (int'(smp_data) > r) ? int'(smp_data) - r : 0;
            end
        end
    end

    initial begin
        #2000000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        smp_valid = 1'b1;
        smp_idx   = 12'd60;
        smp_data  = 12'd777;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(pix_valid == 1'b0, "R1 valid", pix_valid, 0);
        check(pix_data == '0, "R1 data", pix_data, 0);
        check(blk_even == '0 && blk_odd == '0, "R1 levels", blk_even, 0);
        smp_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;
        run_line(0, 1'b0);
        run_line(1, 1'b0);
        run_line(2, 1'b0);
        run_line(3, 1'b1);
        run_line(4, 1'b0);
        drive(1'b0, 1'b0, 0, 0);
        repeat (4) @(negedge clk);
        // R5: levels persist after the last line
        check(blk_even == 12'(exp_blk[0]), "R5 final hold", blk_even, exp_blk[0]);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule